// File: doc/BRIEF.md
# Byte-wide to nibble-wide double-edge Ethernet transmit converter

This block sits between a gigabit MAC transmit port that presents one byte per clock on a single edge, together with an enable and an error flag, and a reduced-pin PHY transmit port. It splits each byte into two nibbles and launches them on both edges of the same 125 MHz clock. The low nibble goes out while the clock is high and the high nibble while it is low, so four lines at double rate carry the full 1000 Mb/s. The enable and the error flag share one control line. The high half of the period carries the enable and the low half carries enable XOR error.

The forwarded clock is the launching clock itself, so clock and data change together. Any sampling skew is left to the PHY or to the board. The stream has no back-pressure and no valid/ready handshake: the MAC side offers a byte every cycle and the block accepts every one, with the enable acting as the valid qualifier. The reset is synchronous and active high. The double-edge output stage is modelled with a rising-edge register set, a falling-edge register set and a per-lane multiplexer selected by the clock level.

Top module: `gmii_rgmii_tx`

## Requirements
- R1: A byte presented before rising edge k is driven in the clock period that begins at rising edge k+1: bits [3:0] on `rg_data_o` while `rg_clk_o` is high, then bits [7:4] while it is low, with no nibble of another byte in between.
- R2: During the high half of that period `rg_ctl_o` equals the enable presented with the byte.
- R3: During the low half of that period `rg_ctl_o` equals the enable XOR the error flag presented with the byte.
- R4: `rg_clk_o` follows `clk_i` with the same polarity and no added delay, so data changes on its edges.
- R5: A byte presented with enable low and error low produces all-zero data and a low control line on both halves of its period, whatever value the byte input carries.
- R6: While `rst_i` is high, data and control are low from the next clock edge of either polarity, and the first period after release is idle.
- R7: A byte presented with enable low and error high is still driven on the data lines in both halves, with control low in the high half and high in the low half.
- R8: Back-to-back enabled bytes are all delivered, one byte per period, in order, with no gap or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz transmit clock, also forwarded |
| rst_i | input | 1 | Synchronous active-high reset |
| gm_byte_i | input | 8 | Byte to transmit |
| gm_en_i | input | 1 | Transmit enable for the byte |
| gm_err_i | input | 1 | Transmit error flag for the byte |
| rg_clk_o | output | 1 | Forwarded transmit clock, edge-aligned |
| rg_data_o | output | 4 | Double-rate nibble data |
| rg_ctl_o | output | 1 | Double-rate control (enable / enable XOR error) |

## Verification
A byte and its flags sampled at one rising edge appear on the pins one full period later. The low nibble and the enable appear in the high half after the next rising edge, and the high nibble and the XOR term appear in the low half after the falling edge that follows. The bench's reference model records the inputs seen at each rising edge and compares them against the pins in the following period. It samples 1.5 ns into the high half and 1.5 ns into the low half, away from every edge. The only exception is reset: a reset asserted after a rising edge already clears the low half of that same period, so the model expects zeros there whenever reset is high at the low-half sample.

// File: rtl/gtr_pkg.sv
`timescale 1ns/1ps
package gtr_pkg;
  // Default nibble width of the double-rate lane group.
  localparam int unsigned NIB_DEF = 4;

  // Which half of the clock period an output lane is presenting.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  // A slot carries data when it is a frame byte or an error-marked slot.
  function automatic logic slot_active(input logic en, input logic er);
    return en | er;
  endfunction
endpackage

// File: rtl/gtr_capture.sv
`timescale 1ns/1ps
module gtr_capture #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              en_i,
  input  logic              er_i,
  output logic [BYTE_W-1:0] cap_byte,
  output logic              cap_en,
  output logic              cap_er
);
  // Input register on the rising edge: the whole byte and both flags
  // are taken together so later stages only see one consistent slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_byte <= '0;
      cap_en   <= 1'b0;
      cap_er   <= 1'b0;
    end else begin
      cap_byte <= byte_i;
      cap_en   <= en_i;
      cap_er   <= er_i;
    end
  end
endmodule

// File: rtl/gtr_launch.sv
`timescale 1ns/1ps
module gtr_launch
  import gtr_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] cap_byte,
  input  logic              cap_en,
  input  logic              cap_er,
  output logic [NIB_W-1:0]  rise_nib,
  output logic              rise_ctl,
  output logic [NIB_W-1:0]  hold_nib,
  output logic              hold_ctl
);
  logic active;
  assign active = slot_active(cap_en, cap_er);

  // Both halves of one slot are loaded at the same rising edge: the
  // rising-phase lanes drive directly, the held half waits for the
  // falling-edge register so it can never pair with another byte.
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_nib <= '0;
      rise_ctl <= 1'b0;
      hold_nib <= '0;
      hold_ctl <= 1'b0;
    end else begin
      rise_nib <= active ? cap_byte[NIB_W-1:0] : '0;
      hold_nib <= active ? cap_byte[BYTE_W-1:NIB_W] : '0;
      rise_ctl <= cap_en;
      hold_ctl <= cap_en ^ cap_er;
    end
  end
endmodule

// File: rtl/gtr_fall.sv
`timescale 1ns/1ps
module gtr_fall #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Falling-edge register set for the low half of each period.
  always_ff @(negedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/gmii_rgmii_tx.sv
`timescale 1ns/1ps
module gmii_rgmii_tx
  import gtr_pkg::*;
#(
  parameter int unsigned NIB_W = NIB_DEF,
  localparam int unsigned BYTE_W = 2 * NIB_W,
  localparam int unsigned LANES  = NIB_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [BYTE_W-1:0] gm_byte_i,
  input  logic              gm_en_i,
  input  logic              gm_err_i,
  output logic              rg_clk_o,
  output logic [NIB_W-1:0]  rg_data_o,
  output logic              rg_ctl_o
);
  logic [BYTE_W-1:0] cap_byte;
  logic              cap_en;
  logic              cap_er;
  logic [NIB_W-1:0]  rise_nib;
  logic              rise_ctl;
  logic [NIB_W-1:0]  hold_nib;
  logic              hold_ctl;
  logic [LANES-1:0]  rise_vec;
  logic [LANES-1:0]  fall_vec;
  logic [LANES-1:0]  pin_vec;

  gtr_capture #(.NIB_W(NIB_W)) u_capture (
    .clk      (clk_i),
    .rst      (rst_i),
    .byte_i   (gm_byte_i),
    .en_i     (gm_en_i),
    .er_i     (gm_err_i),
    .cap_byte (cap_byte),
    .cap_en   (cap_en),
    .cap_er   (cap_er)
  );

  gtr_launch #(.NIB_W(NIB_W)) u_launch (
    .clk      (clk_i),
    .rst      (rst_i),
    .cap_byte (cap_byte),
    .cap_en   (cap_en),
    .cap_er   (cap_er),
    .rise_nib (rise_nib),
    .rise_ctl (rise_ctl),
    .hold_nib (hold_nib),
    .hold_ctl (hold_ctl)
  );

  assign rise_vec = {rise_ctl, rise_nib};

  gtr_fall #(.W(LANES)) u_fall (
    .clk (clk_i),
    .rst (rst_i),
    .d   ({hold_ctl, hold_nib}),
    .q   (fall_vec)
  );

  // Behavioural double-edge output cell, one per lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign pin_vec[g] = (phase_e'(clk_i) == PH_HIGH) ? rise_vec[g] : fall_vec[g];
  end

  assign rg_data_o = pin_vec[NIB_W-1:0];
  assign rg_ctl_o  = pin_vec[NIB_W];
  assign rg_clk_o  = clk_i;

  // R1: low nibble of the byte taken two rising edges ago drives the high half
  a_r1_rise_nibble: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(rst_i, 2)) |->
      rise_nib == (($past(gm_en_i, 2) || $past(gm_err_i, 2)) ?
                   $past(gm_byte_i[NIB_W-1:0], 2) : '0));

  // R1: high nibble of the same byte sits in the falling-edge register
  a_r1_fall_nibble: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(rst_i, 2)) |->
      fall_vec[NIB_W-1:0] == (($past(gm_en_i, 2) || $past(gm_err_i, 2)) ?
                              $past(gm_byte_i[BYTE_W-1:NIB_W], 2) : '0));

  // R2: high-half control is the enable
  a_r2_rise_ctl: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(rst_i, 2)) |-> rise_vec[NIB_W] == $past(gm_en_i, 2));

  // R3: low-half control is enable XOR error
  a_r3_fall_ctl: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(rst_i, 2)) |->
      fall_vec[NIB_W] == ($past(gm_en_i, 2) ^ $past(gm_err_i, 2)));

  // R5: an idle slot leaves every lane low in both halves
  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(rst_i, 2) && !$past(gm_en_i, 2) && !$past(gm_err_i, 2))
      |-> (rise_vec == '0 && fall_vec == '0));

  // R6: a rising edge under reset clears the high-half lanes
  a_r6_reset_clear: assert property (@(posedge clk_i) $past(rst_i) |-> rise_vec == '0);
endmodule

// File: tb/test_gmii_rgmii_tx.sv
`timescale 1ns/1ps
module test_gmii_rgmii_tx;
  logic       clk;
  logic       rst;
  logic [7:0] gm_byte;
  logic       gm_en;
  logic       gm_err;
  logic       rg_clk;
  logic [3:0] rg_data;
  logic       rg_ctl;

  int vectors = 0;
  int fails   = 0;
  bit collect = 1'b0;
  bit done    = 1'b0;
  logic [7:0] sent_q[$];
  logic [7:0] got_q[$];

  gmii_rgmii_tx i_gmii_rgmii_tx (
    .clk_i     (clk),
    .rst_i     (rst),
    .gm_byte_i (gm_byte),
    .gm_en_i   (gm_en),
    .gm_err_i  (gm_err),
    .rg_clk_o  (rg_clk),
    .rg_data_o (rg_data),
    .rg_ctl_o  (rg_ctl)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic en, input logic er);
    @(posedge clk);
    #1;
    gm_byte = b;
    gm_en   = en;
    gm_err  = er;
    if (collect && en) sent_q.push_back(b);
  endtask

  // Reference model: the slot seen at one rising edge is due on the pins
  // in the period that starts at the next rising edge.
  initial begin : model
    logic [7:0] p_byte;
    logic       p_en, p_er, e_rst;
    logic [7:0] e_byte;
    logic       e_en, e_er;
    logic [3:0] exp_lo, exp_hi, got_lo;
    logic       got_en;
    string      tg;
    p_byte = '0; p_en = 1'b0; p_er = 1'b0;
    forever begin
      @(posedge clk);
      e_byte = p_byte; e_en = p_en; e_er = p_er; e_rst = rst;
      if (rst) begin
        e_byte = '0; e_en = 1'b0; e_er = 1'b0;
        p_byte = '0; p_en = 1'b0; p_er = 1'b0;
      end else begin
        p_byte = gm_byte; p_en = gm_en; p_er = gm_err;
      end
      exp_lo = (e_en || e_er) ? e_byte[3:0] : 4'h0;
      exp_hi = (e_en || e_er) ? e_byte[7:4] : 4'h0;
      if (e_rst)               tg = "R6";
      else if (!e_en && !e_er) tg = "R5";
      else if (!e_en)          tg = "R7";
      else                     tg = "";
      #1.5;
      chk(rg_clk == 1'b1, "R4", rg_clk, 1);
      chk(rg_data == exp_lo, (tg == "") ? "R1" : tg, rg_data, exp_lo);
      chk(rg_ctl == e_en, (tg == "") ? "R2" : tg, rg_ctl, e_en);
      got_lo = rg_data;
      got_en = rg_ctl;
      #2.5;
      if (rst) begin
        // reset seen at the falling edge clears the low half too (R6)
        chk(rg_data == 4'h0, "R6", rg_data, 0);
        chk(rg_ctl == 1'b0, "R6", rg_ctl, 0);
      end else begin
        chk(rg_clk == 1'b0, "R4", rg_clk, 0);
        chk(rg_data == exp_hi, (tg == "") ? "R1" : tg, rg_data, exp_hi);
        chk(rg_ctl == (e_en ^ e_er), (tg == "") ? "R3" : tg, rg_ctl, e_en ^ e_er);
        if (collect && got_en) got_q.push_back({rg_data, got_lo});
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    rst = 1'b1; gm_byte = 8'h00; gm_en = 1'b0; gm_err = 1'b0;
    repeat (4) put(8'h00, 1'b0, 1'b0);
    @(posedge clk); #1; rst = 1'b0;
    // R5: idle with garbage on the byte lines
    put(8'hA5, 1'b0, 1'b0);
    put(8'h3C, 1'b0, 1'b0);
    put(8'hFF, 1'b0, 1'b0);
    // R8: back-to-back burst, rebuilt bytes collected and compared
    collect = 1'b1;
    for (int i = 0; i < 24; i++) put(8'((i * 37) + 5), 1'b1, 1'b0);
    repeat (3) put(8'h00, 1'b0, 1'b0);
    collect = 1'b0;
    chk(got_q.size() == sent_q.size(), "R8", got_q.size(), sent_q.size());
    for (int i = 0; i < sent_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == sent_q[i], "R8", got_q[i], sent_q[i]);
    // R3: error-marked bytes inside a frame
    put(8'h12, 1'b1, 1'b0);
    put(8'hE7, 1'b1, 1'b1);
    put(8'h9B, 1'b1, 1'b1);
    put(8'h40, 1'b1, 1'b0);
    // R7: error flag with enable low
    put(8'h0F, 1'b0, 1'b1);
    put(8'hF0, 1'b0, 1'b1);
    put(8'h55, 1'b0, 1'b0);
    // R6: reset in the middle of a frame
    put(8'h81, 1'b1, 1'b0);
    put(8'h7E, 1'b1, 1'b0);
    @(posedge clk); #1; rst = 1'b1; gm_byte = 8'hC3; gm_en = 1'b1;
    repeat (2) put(8'hC3, 1'b1, 1'b1);
    @(posedge clk); #1; rst = 1'b0;
    put(8'h00, 1'b0, 1'b0);
    put(8'h6D, 1'b1, 1'b0);
    repeat (4) put(8'h00, 1'b0, 1'b0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule